// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block sits in front of the transmit data path of an Ethernet MAC. It walks a ring of transmit buffer descriptors held in system memory. It reads each descriptor through a single-outstanding memory port and checks whether software has released the descriptor. If so, it hands the buffer's byte address, length and framing flags to the data fetcher. When the MAC reports that a frame has left, the block writes completion status back into the first descriptor of that frame. In timestamp mode it also writes the captured timestamp.

A descriptor is two 32-bit words, or four words when timestamp mode is selected. Every entry in the ring has the same size. The queue pointer moves forward one descriptor at a time, or returns to the ring base when a descriptor carries the wrap flag. After a frame is aborted, the pointer rewinds to the first descriptor of that frame, so the next start repeats the whole frame. Software controls the walker with an enable level and two pulses: start and halt.

Top module: `txd_ring_walker`

## Requirements
- R1: Reset state. After reset `tx_go`, `mem_req_valid`, `buf_valid`, `tx_err` and `fcs_bad` are all low.
- R2: Descriptor fetch.
  - After a start, the block reads word 0 at the pointer, then word 1 at pointer+4.
  - Word 0 is the buffer byte address. In word 1, bit 15 marks the last buffer and bits 13:0 give the length.
  - The block then presents address, length, last flag and first-buffer flag on the buffer port, holding them until accepted.
  - A zero-length buffer is presented like any other.
  - `buf_nocrc` shows bit 16 of the frame's first descriptor.
- R3: If bit 31 (used) of word 1 is set on the first descriptor of a frame, `tx_go` drops, no buffer is presented and the pointer stays on that descriptor.
- R4: After each presented buffer the pointer advances by 8 bytes (normal) or 16 bytes (timestamp mode). If word 1 bit 30 (wrap) is set, the pointer returns to the base instead. Wrap may sit on any buffer of a frame.
- R5: Writeback.
  - When the MAC reports completion, word 1 of the frame's first descriptor is rewritten to its read value with bit 31 set and bits 29:20 replaced by status.
  - No other descriptor of the frame is written.
- R6: In timestamp mode, when the completion carries a timestamp:
  - status bit 23 is set;
  - word 2 gets seconds[1:0] in bits 31:30 and nanoseconds in bits 29:0;
  - word 3 gets seconds[11:2] in bits 9:0, with zero above.
- R7: Used bit found after the first buffer of a frame.
  - `tx_err` and `fcs_bad` pulse for one cycle.
  - Word 1 of the first descriptor is written with bit 27 set and bit 31 clear.
  - `tx_go` drops, and the next start re-reads the first descriptor of that frame.
- R8: If MAX_BUFS buffers of one frame have been presented without a last flag, the block acts as in R7 right after the last of them.
- R9: MAC error completion.
  - A completion with retry-limit error or late collision sets bit 29 or bit 26 respectively in the writeback, together with bit 31.
  - `tx_go` then drops and the pointer rewinds to the frame's first descriptor.
- R10: A halt pulse takes effect only after the writeback of the frame in progress. The next start continues with the following descriptor.
- R11: Disable and base capture.
  - `tx_go` is low one cycle after `tx_enable` goes low, and the pointer returns to the ring base.
  - Base address and descriptor mode are captured only while the walker is idle and not running.
- R12: The memory port never has more than one read outstanding. A request holds address, direction and write data stable until `mem_req_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base_addr | input | ADDR_W | Ring base byte address |
| cfg_ext_mode | input | 1 | 1 selects four-word descriptors with timestamps |
| tx_enable | input | 1 | Transmit enable level |
| tx_start | input | 1 | Start pulse |
| tx_halt | input | 1 | Halt request pulse |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_we | output | 1 | 1 for write, 0 for read |
| mem_req_addr | output | ADDR_W | Request byte address |
| mem_req_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| buf_valid | output | 1 | Buffer descriptor available |
| buf_ready | input | 1 | Fetcher accepts buffer |
| buf_addr | output | 32 | Buffer byte address |
| buf_len | output | 14 | Buffer length in bytes |
| buf_first | output | 1 | First buffer of frame |
| buf_last | output | 1 | Last buffer of frame |
| buf_nocrc | output | 1 | Frame carries its own CRC |
| done_valid | input | 1 | MAC frame completion pulse |
| done_retry_err | input | 1 | Retry limit exceeded |
| done_late_col | input | 1 | Late collision |
| done_ts_valid | input | 1 | Timestamp captured |
| done_ts_sec | input | 12 | Timestamp seconds |
| done_ts_ns | input | 30 | Timestamp nanoseconds |
| tx_go | output | 1 | Transmit running |
| tx_err | output | 1 | Frame corruption pulse |
| fcs_bad | output | 1 | Force bad FCS pulse |

## Verification
Read data returns one cycle after a read is accepted. The bench memory withdraws ready on every third cycle and the buffer sink on every fourth, so each fetch and writeback lasts a varying number of cycles. Most checks therefore wait until `tx_go` falls and the port goes quiet, then compare memory contents, logged handshakes and logged read addresses on a falling edge. The disable response is due exactly one clock after `tx_enable` drops, and is sampled on the next falling edge.

// File: rtl/txd_pkg.sv
package txd_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned LEN_W     = 14;
  localparam int unsigned BIT_USED  = 31;
  localparam int unsigned BIT_WRAP  = 30;
  localparam int unsigned BIT_RETRY = 29;
  localparam int unsigned BIT_CORR  = 27;
  localparam int unsigned BIT_LATE  = 26;
  localparam int unsigned BIT_TS    = 23;
  localparam int unsigned BIT_NOCRC = 16;
  localparam int unsigned BIT_LAST  = 15;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_HAND,
    ST_DONE_WAIT,
    ST_WB_REQ
  } txd_state_e;
endpackage

// File: rtl/txd_qptr.sv
module txd_qptr #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_base,
  input  logic [ADDR_W-1:0] base,
  input  logic              ext_mode,
  input  logic              advance,
  input  logic              wrap,
  input  logic              mark,
  input  logic              rewind,
  output logic [ADDR_W-1:0] cur,
  output logic [ADDR_W-1:0] frm
);
  localparam logic [ADDR_W-1:0] STRIDE_N = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] STRIDE_X = ADDR_W'(16);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur <= '0;
      frm <= '0;
    end else if (load_base) begin
      cur <= base;
      frm <= base;
    end else if (rewind) begin
      cur <= frm;
    end else begin
      if (advance) cur <= wrap ? base : cur + (ext_mode ? STRIDE_X : STRIDE_N);
      if (mark)    frm <= cur;
    end
  end
endmodule

// File: rtl/txd_wb_build.sv
module txd_wb_build
  import txd_pkg::*;
(
  input  logic [WORD_W-1:0] first_ctl,
  input  logic [1:0]        widx,
  input  logic              set_used,
  input  logic              retry,
  input  logic              corrupt,
  input  logic              late,
  input  logic              ts,
  input  logic [11:0]       ts_sec,
  input  logic [29:0]       ts_ns,
  output logic [WORD_W-1:0] wdata
);
  logic [WORD_W-1:0] stat_w;

  always_comb begin
    stat_w            = first_ctl;
    stat_w[29:20]     = '0;
    stat_w[BIT_USED]  = set_used;
    stat_w[BIT_RETRY] = retry;
    stat_w[BIT_CORR]  = corrupt;
    stat_w[BIT_LATE]  = late;
    stat_w[BIT_TS]    = ts;
    case (widx)
      2'd2:    wdata = {ts_sec[1:0], ts_ns};
      2'd3:    wdata = {22'd0, ts_sec[11:2]};
      default: wdata = stat_w;
    endcase
  end
endmodule

// File: rtl/txd_ring_walker.sv
module txd_ring_walker
  import txd_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned MAX_BUFS = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cfg_base_addr,
  input  logic              cfg_ext_mode,
  input  logic              tx_enable,
  input  logic              tx_start,
  input  logic              tx_halt,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [31:0]       mem_req_wdata,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  output logic              buf_valid,
  input  logic              buf_ready,
  output logic [31:0]       buf_addr,
  output logic [13:0]       buf_len,
  output logic              buf_first,
  output logic              buf_last,
  output logic              buf_nocrc,
  input  logic              done_valid,
  input  logic              done_retry_err,
  input  logic              done_late_col,
  input  logic              done_ts_valid,
  input  logic [11:0]       done_ts_sec,
  input  logic [29:0]       done_ts_ns,
  output logic              tx_go,
  output logic              tx_err,
  output logic              fcs_bad
);
  localparam int unsigned CNT_W = $clog2(MAX_BUFS + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(MAX_BUFS - 1);

  txd_state_e        state;
  logic [1:0]        widx;
  logic [CNT_W-1:0]  nbuf;
  logic [ADDR_W-1:0] base_q;
  logic              ext_q;
  logic              go_q;
  logic              halt_pend;
  logic              rd_out;
  logic [31:0]       addr_q;
  logic [LEN_W-1:0]  len_q;
  logic              last_q;
  logic              wrap_q;
  logic [31:0]       first_ctl_q;
  logic              retry_q, late_q, corrupt_q, ts_q;
  logic [11:0]       sec_q;
  logic [29:0]       ns_q;

  logic [ADDR_W-1:0] cur, frm, word_off;
  logic              rd_ctl, ctl_used, p_mark, p_adv, p_rewind;
  logic              wb_fire, wb_last, err_any;

  // Combinational decode of the current step
  assign word_off = ADDR_W'({widx, 2'b00});
  assign rd_ctl   = (state == ST_RD_WAIT) && mem_rvalid && (widx == 2'd1);
  assign ctl_used = mem_rdata[BIT_USED];
  assign err_any  = retry_q | late_q | corrupt_q;
  assign wb_fire  = (state == ST_WB_REQ) && mem_req_ready;
  assign wb_last  = ((widx == 2'd1) && !ts_q) || (widx == 2'd3);
  assign p_mark   = tx_enable && rd_ctl && !ctl_used && (nbuf == '0) && !halt_pend;
  assign p_adv    = tx_enable && (state == ST_HAND) && buf_ready;
  assign p_rewind = tx_enable && wb_fire && wb_last && err_any;

  txd_qptr #(.ADDR_W(ADDR_W)) u_qptr (
    .clk      (clk),
    .rst      (rst),
    .load_base(!tx_enable),
    .base     (base_q),
    .ext_mode (ext_q),
    .advance  (p_adv),
    .wrap     (wrap_q),
    .mark     (p_mark),
    .rewind   (p_rewind),
    .cur      (cur),
    .frm      (frm)
  );

  txd_wb_build u_wb (
    .first_ctl(first_ctl_q),
    .widx     (widx),
    .set_used (!corrupt_q),
    .retry    (retry_q),
    .corrupt  (corrupt_q),
    .late     (late_q),
    .ts       (ts_q),
    .ts_sec   (sec_q),
    .ts_ns    (ns_q),
    .wdata    (mem_req_wdata)
  );

  // Port outputs
  assign mem_req_valid = ((state == ST_RD_REQ) && !rd_out) || (state == ST_WB_REQ);
  assign mem_req_we    = (state == ST_WB_REQ);
  assign mem_req_addr  = (state == ST_WB_REQ) ? frm + word_off : cur + word_off;
  assign buf_valid     = (state == ST_HAND);
  assign buf_addr      = addr_q;
  assign buf_len       = len_q;
  assign buf_last      = last_q;
  assign buf_first     = (nbuf == '0);
  assign buf_nocrc     = first_ctl_q[BIT_NOCRC];
  assign tx_go         = go_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      widx        <= '0;
      nbuf        <= '0;
      base_q      <= '0;
      ext_q       <= 1'b0;
      go_q        <= 1'b0;
      halt_pend   <= 1'b0;
      rd_out      <= 1'b0;
      addr_q      <= '0;
      len_q       <= '0;
      last_q      <= 1'b0;
      wrap_q      <= 1'b0;
      first_ctl_q <= '0;
      retry_q     <= 1'b0;
      late_q      <= 1'b0;
      corrupt_q   <= 1'b0;
      ts_q        <= 1'b0;
      sec_q       <= '0;
      ns_q        <= '0;
      tx_err      <= 1'b0;
      fcs_bad     <= 1'b0;
    end else begin
      tx_err  <= 1'b0;
      fcs_bad <= 1'b0;

      if (mem_req_valid && mem_req_ready && !mem_req_we) rd_out <= 1'b1;
      else if (mem_rvalid)                              rd_out <= 1'b0;

      if ((state == ST_IDLE) && !go_q) begin
        base_q <= cfg_base_addr;
        ext_q  <= cfg_ext_mode;
      end

      if (!tx_enable) begin
        state     <= ST_IDLE;
        go_q      <= 1'b0;
        halt_pend <= 1'b0;
      end else begin
        if (tx_halt && go_q) halt_pend <= 1'b1;
        case (state)
          ST_IDLE: begin
            if (tx_start) begin
              go_q  <= 1'b1;
              widx  <= '0;
              nbuf  <= '0;
              state <= ST_RD_REQ;
            end
          end
          ST_RD_REQ: begin
            if (mem_req_valid && mem_req_ready) state <= ST_RD_WAIT;
          end
          ST_RD_WAIT: begin
            if (mem_rvalid) begin
              if (widx == 2'd0) begin
                addr_q <= mem_rdata;
                widx   <= 2'd1;
                state  <= ST_RD_REQ;
              end else if (ctl_used) begin
                if (nbuf == '0) begin
                  go_q      <= 1'b0;
                  halt_pend <= 1'b0;
                  state     <= ST_IDLE;
                end else begin
                  corrupt_q <= 1'b1;
                  tx_err    <= 1'b1;
                  fcs_bad   <= 1'b1;
                  widx      <= 2'd1;
                  state     <= ST_WB_REQ;
                end
              end else if ((nbuf == '0) && halt_pend) begin
                go_q      <= 1'b0;
                halt_pend <= 1'b0;
                state     <= ST_IDLE;
              end else begin
                len_q  <= mem_rdata[LEN_W-1:0];
                last_q <= mem_rdata[BIT_LAST];
                wrap_q <= mem_rdata[BIT_WRAP];
                if (nbuf == '0) begin
                  first_ctl_q <= mem_rdata;
                  retry_q     <= 1'b0;
                  late_q      <= 1'b0;
                  corrupt_q   <= 1'b0;
                  ts_q        <= 1'b0;
                end
                state <= ST_HAND;
              end
            end
          end
          ST_HAND: begin
            if (buf_ready) begin
              nbuf <= nbuf + 1'b1;
              widx <= '0;
              if (last_q) begin
                state <= ST_DONE_WAIT;
              end else if (nbuf == LAST_IDX) begin
                corrupt_q <= 1'b1;
                tx_err    <= 1'b1;
                fcs_bad   <= 1'b1;
                widx      <= 2'd1;
                state     <= ST_WB_REQ;
              end else begin
                state <= ST_RD_REQ;
              end
            end
          end
          ST_DONE_WAIT: begin
            if (done_valid) begin
              retry_q <= done_retry_err;
              late_q  <= done_late_col;
              ts_q    <= done_ts_valid && ext_q;
              sec_q   <= done_ts_sec;
              ns_q    <= done_ts_ns;
              widx    <= 2'd1;
              state   <= ST_WB_REQ;
            end
          end
          ST_WB_REQ: begin
            if (mem_req_ready) begin
              if (!wb_last) begin
                widx <= widx + 2'd1;
              end else if (err_any || halt_pend) begin
                go_q      <= 1'b0;
                halt_pend <= 1'b0;
                state     <= ST_IDLE;
              end else begin
                widx  <= '0;
                nbuf  <= '0;
                state <= ST_RD_REQ;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/txd_ring_walker_chk.sv
module txd_ring_walker_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              tx_enable,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_we,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [31:0]       mem_req_wdata,
  input logic              mem_rvalid,
  input logic              buf_valid,
  input logic              buf_ready,
  input logic [31:0]       buf_addr,
  input logic [13:0]       buf_len,
  input logic              buf_last,
  input logic              tx_go,
  input logic              tx_err,
  input logic              fcs_bad
);
  logic pend;

  always_ff @(posedge clk) begin
    if (rst) pend <= 1'b0;
    else if (mem_req_valid && mem_req_ready && !mem_req_we) pend <= 1'b1;
    else if (mem_rvalid) pend <= 1'b0;
  end

  assert_req_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready && tx_enable) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we) && $stable(mem_req_wdata)));

  assert_one_read_R12: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_we) |-> !pend);

  assert_buf_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (buf_valid && !buf_ready && tx_enable) |=>
      (buf_valid && $stable(buf_addr) && $stable(buf_len) && $stable(buf_last)));

  assert_disable_R11: assert property (@(posedge clk) disable iff (rst)
    !tx_enable |=> (!tx_go && !buf_valid));

  assert_err_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    tx_err |=> !tx_err);

  assert_fcs_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    fcs_bad |=> !fcs_bad);

  assert_buf_running_R3: assert property (@(posedge clk) disable iff (rst)
    buf_valid |-> tx_go);
endmodule

bind txd_ring_walker txd_ring_walker_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/txd_ring_walker_bench.sv
`timescale 1ns/1ps
module txd_ring_walker_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] cfg_base_addr = 32'h100;
  logic        cfg_ext_mode = 1'b0;
  logic        tx_enable = 1'b1;
  logic        tx_start = 1'b0;
  logic        tx_halt = 1'b0;
  logic        mem_req_valid, mem_req_ready, mem_req_we;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        buf_valid, buf_ready, buf_first, buf_last, buf_nocrc;
  logic [31:0] buf_addr;
  logic [13:0] buf_len;
  logic        done_valid = 1'b0;
  logic        mac_retry = 1'b0, mac_late = 1'b0, mac_ts = 1'b0, mac_hold = 1'b0;
  logic [11:0] mac_sec = '0;
  logic [29:0] mac_ns = '0;
  logic        tx_go, tx_err, fcs_bad;

  always #10 clk = ~clk;

  txd_ring_walker #(.ADDR_W(32), .MAX_BUFS(4)) u_txd_ring_walker (
    .clk(clk), .rst(rst), .cfg_base_addr(cfg_base_addr), .cfg_ext_mode(cfg_ext_mode),
    .tx_enable(tx_enable), .tx_start(tx_start), .tx_halt(tx_halt),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .buf_valid(buf_valid), .buf_ready(buf_ready), .buf_addr(buf_addr), .buf_len(buf_len),
    .buf_first(buf_first), .buf_last(buf_last), .buf_nocrc(buf_nocrc),
    .done_valid(done_valid), .done_retry_err(mac_retry), .done_late_col(mac_late),
    .done_ts_valid(mac_ts), .done_ts_sec(mac_sec), .done_ts_ns(mac_ns),
    .tx_go(tx_go), .tx_err(tx_err), .fcs_bad(fcs_bad)
  );

  // Memory model and MAC model
  logic [31:0] mem [0:511];
  int unsigned cyc = 0;
  logic        clr_log = 1'b0;
  int          rd_n = 0, hand_n = 0, err_n = 0, fcs_n = 0, dcnt = 0;
  logic        dwait = 1'b0;
  logic [31:0] rd_first = '0, rd_last = '0;
  logic [31:0] h_addr [0:15];
  logic [13:0] h_len  [0:15];
  logic        h_last [0:15];
  logic        h_first[0:15];
  logic        h_nocrc[0:15];

  assign mem_req_ready = (cyc % 3) != 2;
  assign buf_ready     = (cyc % 4) != 1;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_rvalid <= 1'b0;
    done_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_we) mem[mem_req_addr[10:2]] <= mem_req_wdata;
      else begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem[mem_req_addr[10:2]];
      end
    end
    if (clr_log) begin
      rd_n <= 0; hand_n <= 0; err_n <= 0; fcs_n <= 0;
    end else begin
      if (mem_req_valid && mem_req_ready && !mem_req_we) begin
        if (rd_n == 0) rd_first <= mem_req_addr;
        rd_last <= mem_req_addr;
        rd_n <= rd_n + 1;
      end
      if (buf_valid && buf_ready) begin
        if (hand_n < 16) begin
          h_addr[hand_n] <= buf_addr; h_len[hand_n] <= buf_len; h_last[hand_n] <= buf_last;
          h_first[hand_n] <= buf_first; h_nocrc[hand_n] <= buf_nocrc;
        end
        hand_n <= hand_n + 1;
      end
      if (tx_err)  err_n <= err_n + 1;
      if (fcs_bad) fcs_n <= fcs_n + 1;
    end
    if (buf_valid && buf_ready && buf_last) begin
      dwait <= 1'b1; dcnt <= 3;
    end else if (dwait && !mac_hold) begin
      if (dcnt == 0) begin done_valid <= 1'b1; dwait <= 1'b0; end
      else dcnt <= dcnt - 1;
    end
  end

  int checks = 0, failures = 0;
  bit finished = 1'b0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic put_desc(logic [31:0] a, logic [31:0] w0, logic [31:0] w1);
    mem[a[10:2]]     = w0;
    mem[a[10:2] + 1] = w1;
  endtask

  task automatic reinit(logic [31:0] base, logic ext);
    mac_hold = 1'b0;
    repeat (12) @(negedge clk);
    tx_enable = 1'b0; cfg_base_addr = base; cfg_ext_mode = ext;
    mac_retry = 1'b0; mac_late = 1'b0; mac_ts = 1'b0;
    for (int i = 0; i < 512; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    tx_enable = 1'b1;
    clear_log();
  endtask

  task automatic clear_log();
    @(negedge clk) clr_log = 1'b1;
    @(negedge clk) clr_log = 1'b0;
  endtask

  task automatic kick();
    @(negedge clk) tx_start = 1'b1;
    @(negedge clk) tx_start = 1'b0;
  endtask

  task automatic wait_stop();
    int n = 0;
    while (tx_go && n < 3000) begin @(negedge clk); n++; end
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_hand(int k);
    int n = 0;
    while (hand_n < k && n < 3000) begin @(negedge clk); n++; end
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "tx_go", tx_go, 0);
    chk("R1", "req_valid", mem_req_valid, 0);
    chk("R1", "buf_valid", buf_valid, 0);
    chk("R1", "err/fcs", {tx_err, fcs_bad}, 0);
  endtask

  task automatic t_single();
    reinit(32'h100, 1'b0);
    put_desc(32'h100, 32'h1000, 32'h0001_803C);
    put_desc(32'h108, 32'h0,    32'h8000_0000);
    kick(); wait_stop();
    chk("R2", "hand count", hand_n, 1);
    chk("R2", "buf addr", h_addr[0], 32'h1000);
    chk("R2", "buf len", h_len[0], 60);
    chk("R2", "last/first/nocrc", {h_last[0], h_first[0], h_nocrc[0]}, 3'b111);
    chk("R5", "d0 word1", mem[32'h104 >> 2], 32'h8001_803C);
    chk("R3", "go after used", tx_go, 0);
    chk("R3", "stopped at d1 word1", rd_last, 32'h10C);
  endtask

  task automatic t_multi_wrap();
    reinit(32'h100, 1'b0);
    put_desc(32'h100, 32'h2000, 32'h0000_0064);
    put_desc(32'h108, 32'h2100, 32'h0000_8000);
    put_desc(32'h110, 32'h2200, 32'h4000_8008);
    kick(); wait_stop();
    chk("R2", "hand count", hand_n, 3);
    chk("R2", "zero length buffer", h_len[1], 0);
    chk("R2", "second buf not first", h_first[1], 0);
    chk("R5", "frame1 first desc", mem[32'h104 >> 2], 32'h8000_0064);
    chk("R5", "frame1 second desc untouched", mem[32'h10C >> 2], 32'h0000_8000);
    chk("R5", "frame2 desc", mem[32'h114 >> 2], 32'hC000_8008);
    chk("R4", "wrapped to base", rd_last, 32'h104);
  endtask

  task automatic t_ext();
    reinit(32'h100, 1'b1);
    put_desc(32'h100, 32'h3000, 32'h0000_8040);
    put_desc(32'h110, 32'h0,    32'h8000_0000);
    mac_ts = 1'b1; mac_sec = 12'hABD; mac_ns = 30'h0123_4567;
    kick(); wait_stop();
    chk("R6", "word1 with ts flag", mem[32'h104 >> 2], 32'h8080_8040);
    chk("R6", "word2", mem[32'h108 >> 2], 32'h4123_4567);
    chk("R6", "word3", mem[32'h10C >> 2], 32'h0000_02AF);
    chk("R4", "16 byte stride", rd_last, 32'h114);
  endtask

  task automatic t_midused();
    reinit(32'h100, 1'b0);
    put_desc(32'h100, 32'h4000, 32'h0000_0010);
    put_desc(32'h108, 32'h4100, 32'h8000_8004);
    kick(); wait_stop();
    chk("R7", "hand count", hand_n, 1);
    chk("R7", "err pulses", err_n, 1);
    chk("R7", "fcs pulses", fcs_n, 1);
    chk("R7", "corrupt status", mem[32'h104 >> 2], 32'h0800_0010);
    chk("R7", "go dropped", tx_go, 0);
    mem[32'h10C >> 2] = 32'h0000_8004;
    put_desc(32'h110, 32'h0, 32'h8000_0000);
    clear_log();
    kick(); wait_stop();
    chk("R7", "restart read addr", rd_first, 32'h100);
    chk("R7", "restart buffers", hand_n, 2);
    chk("R7", "restart first addr", h_addr[0], 32'h4000);
    chk("R7", "status after resend", mem[32'h104 >> 2], 32'h8000_0010);
  endtask

  task automatic t_overflow();
    reinit(32'h100, 1'b0);
    for (int i = 0; i < 6; i++) put_desc(32'h100 + 32'(i * 8), 32'h5000 + 32'(i), 32'h0000_0001);
    kick(); wait_stop();
    chk("R8", "buffers before abort", hand_n, 4);
    chk("R8", "err pulses", err_n, 1);
    chk("R8", "corrupt status", mem[32'h104 >> 2], 32'h0800_0001);
    chk("R8", "no fifth read", rd_last, 32'h11C);
  endtask

  task automatic t_macerr();
    reinit(32'h100, 1'b0);
    put_desc(32'h100, 32'h5000, 32'h0000_8020);
    put_desc(32'h108, 32'h5100, 32'h0000_8001);
    mac_retry = 1'b1;
    kick(); wait_stop();
    chk("R9", "retry status", mem[32'h104 >> 2], 32'hA000_8020);
    chk("R9", "go dropped", tx_go, 0);
    chk("R9", "one buffer", hand_n, 1);
    mac_retry = 1'b0; mac_late = 1'b1;
    clear_log();
    kick(); wait_stop();
    chk("R9", "rewound read addr", rd_first, 32'h100);
    chk("R9", "nothing sent after rewind", hand_n, 0);
    mem[32'h104 >> 2] = 32'h0000_8020;
    clear_log();
    kick(); wait_stop();
    chk("R9", "late collision status", mem[32'h104 >> 2], 32'h8400_8020);
  endtask

  task automatic t_halt();
    reinit(32'h100, 1'b0);
    put_desc(32'h100, 32'h6000, 32'h0000_800A);
    put_desc(32'h108, 32'h6100, 32'h0000_8014);
    put_desc(32'h110, 32'h0,    32'h8000_0000);
    mac_hold = 1'b1;
    kick(); wait_hand(1);
    @(negedge clk) tx_halt = 1'b1;
    @(negedge clk) tx_halt = 1'b0;
    chk("R10", "still running", tx_go, 1);
    mac_hold = 1'b0;
    wait_stop();
    chk("R10", "one frame", hand_n, 1);
    chk("R10", "frame written", mem[32'h104 >> 2], 32'h8000_800A);
    chk("R10", "next untouched", mem[32'h10C >> 2], 32'h0000_8014);
    clear_log();
    kick(); wait_stop();
    chk("R10", "resume next desc", h_addr[0], 32'h6100);
    chk("R10", "resume count", hand_n, 1);
  endtask

  task automatic t_disable();
    reinit(32'h100, 1'b0);
    put_desc(32'h100, 32'h6000, 32'h0000_8005);
    put_desc(32'h108, 32'h0,    32'h8000_0000);
    mac_hold = 1'b1;
    kick(); wait_hand(1);
    cfg_base_addr = 32'h180;
    mac_hold = 1'b0;
    wait_stop();
    chk("R11", "base ignored while running", rd_last, 32'h10C);
    reinit(32'h180, 1'b0);
    put_desc(32'h180, 32'h7000, 32'h0000_8007);
    mac_hold = 1'b1;
    kick(); wait_hand(1);
    chk("R11", "new base used", h_addr[0], 32'h7000);
    chk("R11", "new base read addr", rd_first, 32'h180);
    @(negedge clk) tx_enable = 1'b0;
    @(negedge clk);
    chk("R11", "go low after disable", tx_go, 0);
    chk("R11", "no request after disable", mem_req_valid, 0);
    tx_enable = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_single();
    t_multi_wrap();
    t_ext();
    t_midused();
    t_overflow();
    t_macerr();
    t_halt();
    t_disable();
    repeat (5) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #3000000;
    if (!finished) begin
      finished = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog run did not complete actual=%0d expected=0", 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule